// File: doc/BRIEF.md
# Dual-Group Synchronous Clock Divider

This block derives two divided clocks from a single input clock. The first group divides by 2 or by 4 under one select bit. The second group divides by 4, 5 or 6 under a two-bit select. Both groups have their own phase counter, and both counters advance on the same rising input edge. After a master reset the counters start together, so any rising edge that the two groups share falls on the same input edge.

A common enable starts and stops both divided clocks together. The enable is captured on the falling input edge, which is the half-cycle in which the internal clock is low. Because of this, a start or stop never cuts a level short. Each output changes only on a rising input edge. While the block is disabled, each output holds its level.

An asynchronous active-low master reset clears both counters and forces both outputs low. Select changes are taken in only at the end of a lane's current output period.

Top module: `clkdiv_dual_group`

## Requirements
- R1: Group A output `clk_a` has a period of 2 input cycles when `sel_a`=0 and 4 input cycles when `sel_a`=1. The duty cycle is 50%, and each period starts with its high part.
- R2: Group B output `clk_b` has a period of 4 input cycles for `sel_b`=2'b00, 6 for 2'b01, and 5 for 2'b10 or 2'b11. Ratios 4 and 6 give a 50% duty cycle. Ratio 5 gives 2 cycles high followed by 3 cycles low.
- R3: After reset is released, both outputs rise on the same first enabled rising edge. From then on, with the selects held, the two outputs rise together every least-common-multiple of the two ratios (12 input cycles for /4 with /6).
- R4: The enable is sampled on the falling input edge. The value sampled there decides whether the next rising edge advances both counters. On a rising edge that does not advance, both outputs and both counters hold. Counting later resumes from the held phase.
- R5: Outputs change only on rising input edges, so no high or low pulse is shorter than one input cycle, including across enable toggles.
- R6: Master reset `mr_n`=0 forces both outputs low at once, without waiting for a clock edge, and clears the enable capture. After release, both outputs rise on the first rising edge that follows a falling edge with `en`=1.
- R7: A change on `sel_a` or `sel_b` takes effect only when the lane finishes its current period, so no period is truncated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| mr_n | input | 1 | Asynchronous active-low master reset |
| en | input | 1 | Common enable, sampled on the falling edge of clk_in |
| sel_a | input | 1 | Group A ratio select: 0 gives /2, 1 gives /4 |
| sel_b | input | 2 | Group B ratio select: 00 gives /4, 01 gives /6, 10 or 11 gives /5 |
| clk_a | output | 1 | Group A divided clock |
| clk_b | output | 1 | Group B divided clock |

## Verification
Four properties are checked on every cycle:
- both outputs are low while reset is held;
- both outputs hold on any edge the captured enable blocks;
- each lane's active ratio changes only at its terminal count;
- each group A rising edge follows a terminal count.

The exact period lengths and high/low split for every select code, the coincidence of rising edges between the groups, and the way the phase resumes after the enable stops and restarts can only be shown by the bench's scenarios. The bench compares every rising edge against a cycle model built from the requirements. It also confirms that neither output moves between rising edges.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned CNT_W   = 3;
  localparam int unsigned NUM_GRP = 2;
  localparam int unsigned GRP_A   = 0;
  localparam int unsigned GRP_B   = 1;

  typedef logic [CNT_W-1:0] ratio_t;

  // Group A: one select bit picks /2 or /4
  function automatic ratio_t ratio_a(input logic s);
    return s ? ratio_t'(4) : ratio_t'(2);
  endfunction

  // Group B: 00 -> /4, 01 -> /6, 10 and 11 -> /5
  function automatic ratio_t ratio_b(input logic [1:0] s);
    case (s)
      2'b00:   return ratio_t'(4);
      2'b01:   return ratio_t'(6);
      default: return ratio_t'(5);
    endcase
  endfunction
endpackage

// File: rtl/clkdiv_en_capture.sv
module clkdiv_en_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic en_q
);
  // Captured while the clock is low; it governs the following rising edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en;
  end
endmodule

// File: rtl/clkdiv_lane.sv
module clkdiv_lane #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [CW-1:0] ratio_in,
  output logic          div_clk,
  output logic          at_term,
  output logic [CW-1:0] ratio_cur
);
  localparam logic [CW-1:0] RST_RATIO = CW'(2);
  localparam logic [CW-1:0] ONE       = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] ratio_q, ratio_d;
  logic          out_q, out_d;

  // Reset count is all ones, so the first advance is always a terminal count.
  assign at_term = (cnt_q >= (ratio_q - ONE));

  always_comb begin
    cnt_d   = cnt_q;
    ratio_d = ratio_q;
    out_d   = out_q;
    if (adv) begin
      if (at_term) begin
        cnt_d   = '0;
        ratio_d = ratio_in;
      end else begin
        cnt_d = cnt_q + ONE;
      end
      out_d = (cnt_d < (ratio_d >> 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      ratio_q <= RST_RATIO;
      out_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      out_q   <= out_d;
    end
  end

  assign div_clk   = out_q;
  assign ratio_cur = ratio_q;
endmodule

// File: rtl/clkdiv_dual_group.sv
module clkdiv_dual_group
  import clkdiv_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic       clk_in,
  input  logic       mr_n,
  input  logic       en,
  input  logic       sel_a,
  input  logic [1:0] sel_b,
  output logic       clk_a,
  output logic       clk_b
);
  logic                         en_q;
  logic [NUM_GRP-1:0][CW-1:0]   ratio_req;
  logic [NUM_GRP-1:0][CW-1:0]   ratio_cur;
  logic [NUM_GRP-1:0]           term;
  logic [NUM_GRP-1:0]           div_out;

  clkdiv_en_capture u_en (
    .clk   (clk_in),
    .rst_n (mr_n),
    .en    (en),
    .en_q  (en_q)
  );

  assign ratio_req[GRP_A] = CW'(ratio_a(sel_a));
  assign ratio_req[GRP_B] = CW'(ratio_b(sel_b));

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_lane
    clkdiv_lane #(.CW(CW)) u_lane (
      .clk       (clk_in),
      .rst_n     (mr_n),
      .adv       (en_q),
      .ratio_in  (ratio_req[g]),
      .div_clk   (div_out[g]),
      .at_term   (term[g]),
      .ratio_cur (ratio_cur[g])
    );
  end

  assign clk_a = div_out[GRP_A];
  assign clk_b = div_out[GRP_B];
endmodule

// File: rtl/clkdiv_dual_group_chk.sv
module clkdiv_dual_group_chk
  import clkdiv_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input logic                       clk_in,
  input logic                       mr_n,
  input logic                       en_q,
  input logic                       clk_a,
  input logic                       clk_b,
  input logic [NUM_GRP-1:0]         term,
  input logic [NUM_GRP-1:0][CW-1:0] ratio_cur
);
  // R6: reset holds both outputs low
  a_r6_reset_low: assert property (@(negedge clk_in)
    !mr_n |-> (!clk_a && !clk_b));

  // R4: an edge blocked by the captured enable leaves both outputs unchanged
  a_r4_hold_when_off: assert property (@(posedge clk_in) disable iff (!mr_n)
    !en_q |=> ($stable(clk_a) && $stable(clk_b)));

  // R3: a group A rising edge is always the start of a new period
  a_r3_rise_at_term: assert property (@(posedge clk_in) disable iff (!mr_n)
    $rose(clk_a) |-> $past(term[GRP_A]));

  // R7: the active ratio is only replaced at a terminal count
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
    a_r7_ratio_at_term: assert property (@(posedge clk_in) disable iff (!mr_n)
      !term[g] |=> $stable(ratio_cur[g]));
  end
endmodule

bind clkdiv_dual_group clkdiv_dual_group_chk #(.CW(CW)) u_chk (
  .clk_in    (clk_in),
  .mr_n      (mr_n),
  .en_q      (en_q),
  .clk_a     (clk_a),
  .clk_b     (clk_b),
  .term      (term),
  .ratio_cur (ratio_cur)
);

// File: tb/clkdiv_dual_group_bench.sv
`timescale 1ns/1ps
module clkdiv_dual_group_bench;
  localparam real CLK_HALF = 2.5;  // 200 MHz

  logic       clk_in = 1'b0;
  logic       mr_n;
  logic       en;
  logic       sel_a;
  logic [1:0] sel_b;
  logic       clk_a, clk_b;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // cycle model built from the requirements
  int   m_cnt[2];
  int   m_n[2];
  bit   m_run[2];
  logic m_out[2];

  always #(CLK_HALF) clk_in = ~clk_in;

  clkdiv_dual_group u_clkdiv_dual_group (
    .clk_in (clk_in),
    .mr_n   (mr_n),
    .en     (en),
    .sel_a  (sel_a),
    .sel_b  (sel_b),
    .clk_a  (clk_a),
    .clk_b  (clk_b)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int g = 0; g < 2; g++) begin
      m_cnt[g] = 0; m_n[g] = 2; m_run[g] = 0; m_out[g] = 1'b0;
    end
  endtask

  task automatic model_edge(input logic e, input logic sa, input logic [1:0] sb);
    int req[2];
    req[0] = sa ? 4 : 2;
    req[1] = (sb == 2'b00) ? 4 : (sb == 2'b01) ? 6 : 5;
    if (e) begin
      for (int g = 0; g < 2; g++) begin
        if (!m_run[g] || m_cnt[g] == m_n[g] - 1) begin
          m_cnt[g] = 0; m_n[g] = req[g]; m_run[g] = 1;
        end else begin
          m_cnt[g]++;
        end
        m_out[g] = (m_cnt[g] < m_n[g] / 2);
      end
    end
  endtask

  // Called just after a rising edge; ends just after the next rising edge.
  task automatic step(input logic e, input logic sa, input logic [1:0] sb,
                      input string tag_a, input string tag_b);
    logic pa, pb;
    pa = clk_a; pb = clk_b;
    en = e; sel_a = sa; sel_b = sb;
    @(negedge clk_in); #1;
    chk(clk_a, pa, "R5 clk_a moved between rising edges");
    chk(clk_b, pb, "R5 clk_b moved between rising edges");
    @(posedge clk_in); #1;
    model_edge(e, sa, sb);
    chk(clk_a, m_out[0], tag_a);
    chk(clk_b, m_out[1], tag_b);
  endtask

  task automatic do_reset(input logic e, input logic sa, input logic [1:0] sb);
    mr_n = 1'b0; en = e; sel_a = sa; sel_b = sb;
    repeat (2) @(posedge clk_in);
    #1;
    chk(clk_a, 1'b0, "R6 clk_a low in reset");
    chk(clk_b, 1'b0, "R6 clk_b low in reset");
    model_reset();
    mr_n = 1'b1;
  endtask

  task automatic t_ratios();
    for (int sa = 0; sa < 2; sa++) begin
      for (int sb = 0; sb < 4; sb++) begin
        do_reset(1'b1, sa[0], sb[1:0]);
        step(1'b1, sa[0], sb[1:0], "R1 clk_a ratio", "R2 clk_b ratio");
        chk(clk_a, 1'b1, "R3 clk_a first edge");
        chk(clk_b, 1'b1, "R3 clk_b first edge");
        for (int i = 0; i < 35; i++)
          step(1'b1, sa[0], sb[1:0], "R1 clk_a ratio", "R2 clk_b ratio");
      end
    end
  endtask

  task automatic t_align();
    logic pa, pb;
    do_reset(1'b1, 1'b1, 2'b01);
    for (int i = 0; i < 37; i++) begin
      pa = clk_a; pb = clk_b;
      step(1'b1, 1'b1, 2'b01, "R3 clk_a /4", "R3 clk_b /6");
      chk((!pa && clk_a && !pb && clk_b), (i % 12 == 0), "R3 joint rising edge");
    end
  endtask

  task automatic t_enable();
    logic pat[26];
    pat = '{1,1,1,1,1,0,0,0,0,1,1,1,0,1,1,1,1,1,1,1,1,1,1,0,1,1};
    do_reset(1'b1, 1'b1, 2'b10);
    for (int i = 0; i < 26; i++)
      step(pat[i], 1'b1, 2'b10, "R4 clk_a with enable", "R4 clk_b with enable");
  endtask

  task automatic t_select();
    do_reset(1'b1, 1'b0, 2'b00);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 2'b00, "R7 clk_a", "R7 clk_b");
    for (int i = 0; i < 14; i++) step(1'b1, 1'b1, 2'b11, "R7 clk_a", "R7 clk_b");
    for (int i = 0; i < 2; i++) step(1'b1, 1'b1, 2'b01, "R7 clk_a", "R7 clk_b");
    for (int i = 0; i < 14; i++) step(1'b1, 1'b0, 2'b00, "R7 clk_a", "R7 clk_b");
  endtask

  task automatic t_async_reset();
    do_reset(1'b1, 1'b1, 2'b01);
    step(1'b1, 1'b1, 2'b01, "R6 clk_a after release", "R6 clk_b after release");
    chk(clk_a, 1'b1, "R6 clk_a high before reset");
    chk(clk_b, 1'b1, "R6 clk_b high before reset");
    mr_n = 1'b0;
    #1;
    chk(clk_a, 1'b0, "R6 clk_a cleared without edge");
    chk(clk_b, 1'b0, "R6 clk_b cleared without edge");
    @(posedge clk_in); #1;
    mr_n = 1'b1;
  endtask

  initial begin
    mr_n = 1'b0; en = 1'b0; sel_a = 1'b0; sel_b = 2'b00;
    model_reset();
    @(posedge clk_in); #1;
    t_ratios();
    t_align();
    t_enable();
    t_select();
    t_async_reset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_HALF * 2 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule